// File: doc/BRIEF.md
# Processor Boot and Memory Ownership Sequencer

This block sits between one external SRAM port and two would-be masters: a host-side user path that loads programs and reads results, and an embedded processor that runs them. A single run flag decides which side owns the SRAM address, write data and strobes. While the flag is low the user side owns the memory. The processor is held in its boot loop, where it keeps polling a fixed check address. The block answers that poll itself. Bit 1 of the answer carries the run flag, and the processor jumps to the loaded program once that bit reads as one.

The block also watches processor traffic for two events. The first poll of the check address tells the host that the processor has booted, and a one-cycle ready message goes out. A processor write to the fixed completion address tells the host that results are in memory. A one-cycle done message goes out and memory returns to the user. A host start command hands the memory to the processor. A start that arrives before the processor has booted is remembered and takes effect when the boot poll is seen. A host session runs in this order: wait for ready, load, start, wait for done, read back.

Top module: `bootArb`

## Requirements
- R1: After reset the run flag `cpuGo`, `readyMsg` and `doneMsg` are low, and `sramAddr` follows `userAddr`.
- R2: While `cpuGo` is low, `sramAddr`, `sramWrData` and `sramWe` come from the user inputs, and `sramOe` equals `userRd && !userWr`. Processor write and read strobes do not reach the SRAM.
- R3: While `cpuGo` is high, the SRAM address, data and write strobe come from the processor. `sramOe` equals `cpuRd && !cpuWr` except for reads of the check address. User strobes are ignored.
- R4: `sramWe` and `sramOe` are never high together. The block drives the SRAM data lines only while `sramWe` is high and leaves them released otherwise.
- R5: The first processor read of CHECK_ADDR after reset gives a one-cycle `readyMsg` pulse in the following cycle. Later polls give no further pulse until the next reset, including polls after a completion.
- R6: A processor read of CHECK_ADDR returns `cpuRdData` with bit 1 equal to `cpuGo` and every other bit zero, and it never enables the SRAM.
- R7: After ready, a `userStart` pulse sets `cpuGo` high in the next cycle.
- R8: A `userStart` seen before ready is latched and does not raise `cpuGo`. When the boot poll then arrives, `readyMsg` and `cpuGo` both go high in the following cycle.
- R9: A processor write to DONE_ADDR (0x4000_0000) while `cpuGo` is high still reaches the SRAM. In the next cycle `doneMsg` pulses for exactly one cycle and `cpuGo` goes low.
- R10: A processor write to DONE_ADDR while `cpuGo` is low has no effect: there is no `doneMsg`, `cpuGo` stays low and `sramWe` stays low.
- R11: A `userStart` while `cpuGo` is high is ignored. After a completion, a `userStart` sets `cpuGo` high again.
- R12: `userRdData` equals `sramRdData` while `cpuGo` is low and is zero otherwise. `cpuRdData` for any address other than CHECK_ADDR equals `sramRdData` while `cpuGo` is high and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| userAddr | input | AW | Host-side SRAM address |
| userWrData | input | DW | Host-side write data |
| userWr | input | 1 | Host-side write strobe |
| userRd | input | 1 | Host-side read strobe |
| userStart | input | 1 | Host start command, one-cycle pulse |
| userRdData | output | DW | Read data returned to host |
| cpuAddr | input | AW | Processor address bus |
| cpuWrData | input | DW | Processor write data |
| cpuWr | input | 1 | Processor write strobe |
| cpuRd | input | 1 | Processor read strobe |
| cpuRdData | output | DW | Read data returned to processor |
| sramAddr | output | AW | SRAM address |
| sramWrData | output | DW | Data driven onto SRAM data lines |
| sramWe | output | 1 | SRAM write enable; block drives data lines when high |
| sramOe | output | 1 | SRAM output enable |
| sramRdData | input | DW | Data read from SRAM |
| cpuGo | output | 1 | Run flag: processor owns memory when high |
| readyMsg | output | 1 | One-cycle processor-ready message request |
| doneMsg | output | 1 | One-cycle completion message request |

## Verification
The ownership mux is tried against one table of mixed vectors in three states: the boot state, the loaded state and the running state. These vectors cover lone user writes, lone user reads, lone processor writes, lone processor reads, all strobes together and idle. They separate a correct select from a swapped or stuck select, from a leak of the non-owner's strobes, and from read and write enables that overlap. The sequencing is driven along the normal path and again with the start issued early. It is also driven with repeated polls, with a completion write made while the processor is held, and with a start made while running. These cases separate single-shot messages from repeating ones, a latched start from a dropped one, and state-qualified event decoding from decoding on the address alone.

// File: rtl/bootArbPkg.sv
package bootArbPkg;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } armState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic go;
  } ctrlStrobe_t;

  // events observed by datapath, consumed by control
  typedef struct packed {
    logic pollHit;
    logic doneHit;
  } watchEvt_t;

endpackage

// File: rtl/bootArbWatch.sv
module bootArbWatch #(
  parameter int AW = 32,
  parameter logic [AW-1:0] MATCH_ADDR = '0
) (
  input  logic [AW-1:0] addr,
  input  logic          strobe,
  output logic          hit
);
  always_comb hit = strobe && (addr == MATCH_ADDR);
endmodule

// File: rtl/bootArbDatapath.sv
module bootArbDatapath
  import bootArbPkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] CHECK_ADDR = '0,
  parameter logic [AW-1:0] DONE_ADDR  = '0,
  parameter int GO_BIT = 1
) (
  input  ctrlStrobe_t   ctrl,
  input  logic [AW-1:0] userAddr,
  input  logic [DW-1:0] userWrData,
  input  logic          userWr,
  input  logic          userRd,
  output logic [DW-1:0] userRdData,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWrData,
  input  logic          cpuWr,
  input  logic          cpuRd,
  output logic [DW-1:0] cpuRdData,
  output logic [AW-1:0] sramAddr,
  output logic [DW-1:0] sramWrData,
  output logic          sramWe,
  output logic          sramOe,
  input  logic [DW-1:0] sramRdData,
  output watchEvt_t     evt
);
  localparam logic [DW-1:0] GO_MASK = DW'(1) << GO_BIT;

  logic pollHit;
  logic doneHit;

  bootArbWatch #(.AW(AW), .MATCH_ADDR(CHECK_ADDR)) pollWatch_i (
    .addr(cpuAddr), .strobe(cpuRd), .hit(pollHit)
  );
  bootArbWatch #(.AW(AW), .MATCH_ADDR(DONE_ADDR)) doneWatch_i (
    .addr(cpuAddr), .strobe(cpuWr), .hit(doneHit)
  );

  always_comb begin
    evt.pollHit = pollHit;
    evt.doneHit = doneHit;
  end

  // ownership mux
  always_comb begin
    if (ctrl.go) begin
      sramAddr   = cpuAddr;
      sramWrData = cpuWrData;
      sramWe     = cpuWr;
      sramOe     = cpuRd && !cpuWr && !pollHit;
    end else begin
      sramAddr   = userAddr;
      sramWrData = userWrData;
      sramWe     = userWr;
      sramOe     = userRd && !userWr;
    end
  end

  // read return paths
  always_comb begin
    userRdData = ctrl.go ? '0 : sramRdData;
    if (pollHit)      cpuRdData = ctrl.go ? GO_MASK : '0;
    else if (ctrl.go) cpuRdData = sramRdData;
    else              cpuRdData = '0;
  end
endmodule

// File: rtl/bootArbCtrl.sv
module bootArbCtrl
  import bootArbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        userStart,
  input  watchEvt_t   evt,
  output ctrlStrobe_t ctrl,
  output logic        readyMsg,
  output logic        doneMsg
);
  armState_e state, stateNext;
  logic startPend, startPendNext;
  logic readyNext, doneNext;

  always_comb begin
    stateNext     = state;
    startPendNext = startPend;
    readyNext     = 1'b0;
    doneNext      = 1'b0;
    unique case (state)
      ST_BOOT: begin
        if (evt.pollHit) begin
          readyNext     = 1'b1;
          startPendNext = 1'b0;
          stateNext     = (startPend || userStart) ? ST_RUN : ST_LOAD;
        end else if (userStart) begin
          startPendNext = 1'b1;
        end
      end
      ST_LOAD: if (userStart) stateNext = ST_RUN;
      ST_RUN: begin
        if (evt.doneHit) begin
          doneNext  = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_DONE: if (userStart) stateNext = ST_RUN;
      default: stateNext = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_BOOT;
      startPend <= 1'b0;
      readyMsg  <= 1'b0;
      doneMsg   <= 1'b0;
    end else begin
      state     <= stateNext;
      startPend <= startPendNext;
      readyMsg  <= readyNext;
      doneMsg   <= doneNext;
    end
  end

  always_comb ctrl.go = (state == ST_RUN);
endmodule

// File: rtl/bootArb.sv
module bootArb
  import bootArbPkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] CHECK_ADDR = AW'(32'h0000_0100),
  parameter logic [AW-1:0] DONE_ADDR  = AW'(32'h4000_0000),
  parameter int GO_BIT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] userAddr,
  input  logic [DW-1:0] userWrData,
  input  logic          userWr,
  input  logic          userRd,
  input  logic          userStart,
  output logic [DW-1:0] userRdData,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWrData,
  input  logic          cpuWr,
  input  logic          cpuRd,
  output logic [DW-1:0] cpuRdData,
  output logic [AW-1:0] sramAddr,
  output logic [DW-1:0] sramWrData,
  output logic          sramWe,
  output logic          sramOe,
  input  logic [DW-1:0] sramRdData,
  output logic          cpuGo,
  output logic          readyMsg,
  output logic          doneMsg
);
  ctrlStrobe_t ctrl;
  watchEvt_t   evt;

  bootArbCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .userStart(userStart), .evt(evt),
    .ctrl(ctrl), .readyMsg(readyMsg), .doneMsg(doneMsg)
  );

  bootArbDatapath #(
    .AW(AW), .DW(DW), .CHECK_ADDR(CHECK_ADDR), .DONE_ADDR(DONE_ADDR), .GO_BIT(GO_BIT)
  ) dp_i (
    .ctrl(ctrl),
    .userAddr(userAddr), .userWrData(userWrData), .userWr(userWr), .userRd(userRd),
    .userRdData(userRdData),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuRdData(cpuRdData),
    .sramAddr(sramAddr), .sramWrData(sramWrData), .sramWe(sramWe), .sramOe(sramOe),
    .sramRdData(sramRdData), .evt(evt)
  );

  always_comb cpuGo = ctrl.go;
endmodule

// File: rtl/bootArbChk.sv
module bootArbChk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] DONE_ADDR = '0
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuGo,
  input logic          readyMsg,
  input logic          doneMsg,
  input logic [AW-1:0] sramAddr,
  input logic [AW-1:0] userAddr,
  input logic [AW-1:0] cpuAddr,
  input logic          sramWe,
  input logic          sramOe,
  input logic          userWr,
  input logic          cpuWr
);
  // R4
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(sramWe && sramOe));

  // R2
  user_owns_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuGo |-> (sramAddr == userAddr) && (sramWe == userWr));

  // R3
  cpu_owns_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuGo |-> (sramAddr == cpuAddr) && (sramWe == cpuWr));

  // R5
  ready_single_chk: assert property (@(posedge clk) disable iff (!rstN) readyMsg |=> !readyMsg);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) doneMsg |=> !doneMsg);

  // R9
  done_drop_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneMsg |-> !cpuGo && $past(cpuGo));

  // R11
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGo && !(cpuWr && cpuAddr == DONE_ADDR)) |=> cpuGo);
endmodule

bind bootArb bootArbChk #(.AW(AW), .DONE_ADDR(DONE_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .cpuGo(cpuGo), .readyMsg(readyMsg), .doneMsg(doneMsg),
  .sramAddr(sramAddr), .userAddr(userAddr), .cpuAddr(cpuAddr),
  .sramWe(sramWe), .sramOe(sramOe), .userWr(userWr), .cpuWr(cpuWr)
);

// File: tb/bootArb_tb.sv
module bootArb_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] CHECK_A = 32'h0000_0100;
  localparam logic [31:0] DONE_A  = 32'h4000_0000;

  typedef struct packed {
    logic [31:0] uA, uD, cA, cD, sR;
    logic uW, uR, cW, cR;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h0000_0010, 32'hA5A5_0001, 32'h0000_0020, 32'h5A5A_0002, 32'h1111_2222, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h0000_0014, 32'hA5A5_0003, 32'h0000_0024, 32'h5A5A_0004, 32'h3333_4444, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h0000_0018, 32'hA5A5_0005, 32'h0000_0028, 32'h5A5A_0006, 32'h5555_6666, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h0000_001C, 32'hA5A5_0007, 32'h0000_002C, 32'h5A5A_0008, 32'h7777_8888, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'h0000_0030, 32'hA5A5_0009, 32'h0000_0040, 32'h5A5A_000A, 32'h9999_AAAA, 1'b1, 1'b1, 1'b1, 1'b1},
    '{32'h0000_0034, 32'hA5A5_000B, 32'h0000_0044, 32'h5A5A_000C, 32'hBBBB_CCCC, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] userAddr = '0, userWrData = '0, cpuAddr = '0, cpuWrData = '0, sramRdData = '0;
  logic userWr = 1'b0, userRd = 1'b0, userStart = 1'b0, cpuWr = 1'b0, cpuRd = 1'b0;
  logic [31:0] userRdData, cpuRdData, sramAddr, sramWrData;
  logic sramWe, sramOe, cpuGo, readyMsg, doneMsg;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bootArb dut_i (
    .clk(clk), .rstN(rstN),
    .userAddr(userAddr), .userWrData(userWrData), .userWr(userWr), .userRd(userRd),
    .userStart(userStart), .userRdData(userRdData),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuRdData(cpuRdData),
    .sramAddr(sramAddr), .sramWrData(sramWrData), .sramWe(sramWe), .sramOe(sramOe),
    .sramRdData(sramRdData), .cpuGo(cpuGo), .readyMsg(readyMsg), .doneMsg(doneMsg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idleInputs();
    userWr = 0; userRd = 0; userStart = 0; cpuWr = 0; cpuRd = 0;
  endtask

  // ownership mux check, expectation derived from R2/R3/R4/R12
  task automatic walkTable(input logic go, input string req);
    for (int i = 0; i < 6; i++) begin
      vec_t v = VEC[i];
      tick();
      userAddr = v.uA; userWrData = v.uD; userWr = v.uW; userRd = v.uR;
      cpuAddr = v.cA; cpuWrData = v.cD; cpuWr = v.cW; cpuRd = v.cR;
      sramRdData = v.sR;
      #1;
      chk({req, " addr"}, 64'(sramAddr),   go ? 64'(v.cA) : 64'(v.uA));
      chk({req, " wdata"}, 64'(sramWrData), go ? 64'(v.cD) : 64'(v.uD));
      chk({req, " we"},   64'(sramWe),     go ? 64'(v.cW) : 64'(v.uW));
      chk({req, " oe"},   64'(sramOe),     go ? 64'(v.cR && !v.cW) : 64'(v.uR && !v.uW));
      chk("R4 excl", 64'(sramWe && sramOe), 64'd0);
      chk("R12 user rd", 64'(userRdData), go ? 64'd0 : 64'(v.sR));
      chk("R12 cpu rd",  64'(cpuRdData),  go ? 64'(v.sR) : 64'd0);
      chk({req, " go"}, 64'(cpuGo), 64'(go));
    end
    tick();
    idleInputs();
  endtask

  task automatic doReset();
    tick();
    rstN = 0;
    idleInputs();
    userAddr = 32'h0000_0077;
    tick(); tick();
    #1;
    chk("R1 go",    64'(cpuGo), 64'd0);
    chk("R1 ready", 64'(readyMsg), 64'd0);
    chk("R1 done",  64'(doneMsg), 64'd0);
    chk("R1 addr",  64'(sramAddr), 64'h77);
    tick();
    rstN = 1;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // phase A: normal flow
    doReset();
    walkTable(1'b0, "R2 boot");

    tick(); cpuRd = 1; cpuAddr = CHECK_A; #1;
    chk("R6 poll held", 64'(cpuRdData), 64'd0);
    chk("R6 poll no oe", 64'(sramOe), 64'd0);
    tick(); #1;
    chk("R5 ready pulse", 64'(readyMsg), 64'd1);
    chk("R5 go stays low", 64'(cpuGo), 64'd0);
    tick(); #1;
    chk("R5 single ready", 64'(readyMsg), 64'd0);
    cpuRd = 0;

    walkTable(1'b0, "R2 load");

    tick(); userStart = 1;
    tick(); userStart = 0; #1;
    chk("R7 start", 64'(cpuGo), 64'd1);

    cpuRd = 1; cpuAddr = CHECK_A; #1;
    chk("R6 poll run", 64'(cpuRdData), 64'h2);
    chk("R6 poll run no oe", 64'(sramOe), 64'd0);
    tick(); cpuRd = 0;

    walkTable(1'b1, "R3 run");

    userStart = 1;
    tick(); userStart = 0;
    tick(); #1;
    chk("R11 start ignored", 64'(cpuGo), 64'd1);

    cpuWr = 1; cpuAddr = DONE_A; cpuWrData = 32'h0000_000D; #1;
    chk("R9 write reaches", 64'(sramWe), 64'd1);
    chk("R9 write addr", 64'(sramAddr), 64'(DONE_A));
    tick(); cpuWr = 0; #1;
    chk("R9 done pulse", 64'(doneMsg), 64'd1);
    chk("R9 go drop", 64'(cpuGo), 64'd0);
    tick(); #1;
    chk("R9 single done", 64'(doneMsg), 64'd0);

    cpuRd = 1; cpuAddr = CHECK_A; #1;
    chk("R6 poll done", 64'(cpuRdData), 64'd0);
    tick(); cpuRd = 0; #1;
    chk("R5 no ready after done", 64'(readyMsg), 64'd0);

    userStart = 1;
    tick(); userStart = 0; #1;
    chk("R11 restart", 64'(cpuGo), 64'd1);

    // phase B: held-state corner cases
    doReset();
    tick(); cpuWr = 1; cpuAddr = DONE_A; #1;
    chk("R10 no we", 64'(sramWe), 64'd0);
    tick(); cpuWr = 0; #1;
    chk("R10 no done", 64'(doneMsg), 64'd0);
    chk("R10 go low", 64'(cpuGo), 64'd0);

    userStart = 1;
    tick(); userStart = 0;
    tick(); #1;
    chk("R8 early start held", 64'(cpuGo), 64'd0);
    cpuRd = 1; cpuAddr = CHECK_A;
    tick(); cpuRd = 0; #1;
    chk("R8 ready", 64'(readyMsg), 64'd1);
    chk("R8 go", 64'(cpuGo), 64'd1);
    tick(); #1;
    chk("R8 ready once", 64'(readyMsg), 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule